// File: doc/BRIEF.md
# Raster LCD Panel Timing Generator

This block turns a single pixel-rate clock into the complete set of strobes a raster LCD panel needs: a pixel shift clock, a line sync, a frame sync, a line load strobe, a frame polarity toggle and a 24-bit pixel data bus. One pixel occupies two cycles of the input clock. The shift clock is high in the first cycle and low in the second. Every other output is registered and changes only at the clock edge that starts a pixel.

Each line is laid out as sync, back porch, active and front porch pixels, and each frame uses the same order in lines. The horizontal counts and the fixed vertical counts are parameters. The frame sync width is a 2-bit input measured in lines. A group of static configuration inputs selects the rest of the behaviour: run/stop, shift-clock gating (forced on in STN mode), an independent polarity for each strobe and for the shift clock, data blanking, the line-load width mode, and the frame-toggle source. Pixel data is sampled at the edge that starts each valid pixel.

Top module: `lcd_raster_timer`

## Requirements
- R1: While `run_i` is 0, from the next clock edge on: `data_o` is zero, `lfr_o` is 0, `sclk_o` rests at the level of `sclk_inv_i`, and `hs_o`, `vs_o` and `ld_o` each rest at the level of their own invert input (their inactive level).
- R2: While stopped, the line and pixel counters are held at zero. Pixel 0 of line 0 appears on the outputs at the first clock edge at which `run_i` is sampled high. Pixel n appears 2n edges later.
- R3: A line has H_SYNC+H_BACK+H_ACT+H_FRONT pixels. The line sync is active during its first H_SYNC pixels.
- R4: The frame sync is active for the first 1, 2 or 3 lines of the frame for `vs_width_i` codes 00, 01 and 10. Code 11 gives 1 line. The frame then has V_BACK, V_ACT and V_FRONT further lines, so the frame length follows the code.
- R5: A pixel is valid only when both its horizontal and vertical positions are in their active regions. For a valid pixel with blanking off, `data_o` carries `pix_i` as sampled at that pixel's starting edge. Otherwise `data_o` is zero.
- R6: With `blank_i` = 1, `data_o` is zero for every pixel, valid or not.
- R7: With `sclk_gate_i` = 0 and `stn_i` = 0, the shift clock runs continuously: it is active in the first cycle of every pixel and idle in the second.
- R8: With `sclk_gate_i` = 1, or with `stn_i` = 1 whatever `sclk_gate_i` holds, the shift clock pulses only in valid pixels and stays idle in all other pixels.
- R9: `sclk_inv_i` = 1 inverts the shift clock. With it at 0, outputs change on the rising shift-clock edge. With it at 1, they change on the falling edge.
- R10: `hs_inv_i`, `vs_inv_i` and `ld_inv_i` each select the sense of their own strobe independently: 0 is active high and 1 is active low.
- R11: With `ld_mode_i` = 0, the load strobe is active in the first LD_WIDTH pixels of every line. With `ld_mode_i` = 1, it is active in exactly the valid pixels.
- R12: `lfr_o` starts at 0 when running begins. With `lfr_sel_i` = 0 it toggles at the first pixel of every line, including the first line after start. With `lfr_sel_i` = 1 it toggles at every pixel.
- R13: The data bus and all strobes other than the shift clock keep their values through the second cycle of each pixel. They change only at the edge that starts a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 runs the timing, 0 stops and clears it |
| sclk_gate_i | input | 1 | 1 limits the shift clock to valid pixels |
| stn_i | input | 1 | STN panel mode; forces shift-clock gating |
| sclk_inv_i | input | 1 | Inverts the shift clock |
| hs_inv_i | input | 1 | Line sync active low when 1 |
| vs_inv_i | input | 1 | Frame sync active low when 1 |
| ld_inv_i | input | 1 | Load strobe active low when 1 |
| vs_width_i | input | 2 | Frame sync width code, in lines |
| blank_i | input | 1 | Forces the data bus to zero |
| ld_mode_i | input | 1 | Load strobe width: 0 fixed count, 1 valid pixels |
| lfr_sel_i | input | 1 | Frame toggle source: 0 per line, 1 per pixel |
| pix_i | input | DATA_W | Pixel data to present |
| sclk_o | output | 1 | Pixel shift clock |
| hs_o | output | 1 | Line sync |
| vs_o | output | 1 | Frame sync |
| ld_o | output | 1 | Line load strobe |
| lfr_o | output | 1 | Frame polarity toggle |
| data_o | output | DATA_W | Pixel data bus |

## Verification
The bench compares every pixel of several frames against its own model of the position. It sweeps all four frame sync codes, so a design that decoded the reserved code as 0 or 4 lines, or that kept a fixed frame length, would shift the valid window and the next frame sync by whole lines. It sets gating through the gate input and through STN mode on its own, to catch a design that honours only one of them with stray shift-clock pulses in blanking. It also stops in the middle of a line and restarts, so a design that forgot to clear the counters or the frame toggle would begin off pixel 0 or start the toggle from the wrong phase. Each pixel is sampled in both halves, which exposes any strobe that moves on the wrong edge or with the wrong polarity.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  // Strobe levels for one pixel position, before polarity is applied.
  typedef struct packed {
    logic hs;
    logic vs;
    logic ld;
    logic de;
  } lcd_strobe_t;

  // Frame sync width in lines for the 2-bit width code; code 3 falls back to 1.
  function automatic int unsigned vs_lines(input logic [1:0] code);
    case (code)
      2'b01:   return 2;
      2'b10:   return 3;
      default: return 1;
    endcase
  endfunction

  // True when pos lies in [first, first+len).
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned first,
                                   input int unsigned len);
    return (pos >= first) && (pos < first + len);
  endfunction

endpackage

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  // A count at or beyond the limit wraps, so a shortened limit never strands it.
  assign wrap_o = adv_i && (cnt_o >= last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clr_i || wrap_o) begin
      cnt_o <= '0;
    end else if (adv_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R2: a stopped axis sits at zero
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

  // R3: positions within a line or frame step by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && adv_i && !wrap_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/lcd_sclk_gen.sv
module lcd_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic gate_i,
  input  logic valid_i,
  input  logic sclk_inv_i,
  output logic upd_o,
  output logic tick_o,
  output logic phase_o,
  output logic sclk_raw_o,
  output logic sclk_o
);

  logic inv_q;

  // upd_o: edge that starts a pixel; tick_o: edge that ends it.
  assign upd_o  = run_i && !phase_o;
  assign tick_o = run_i && phase_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o    <= 1'b0;
      sclk_raw_o <= 1'b0;
      inv_q      <= 1'b0;
    end else begin
      inv_q <= sclk_inv_i;
      if (!run_i) begin
        phase_o    <= 1'b0;
        sclk_raw_o <= 1'b0;
      end else begin
        phase_o    <= !phase_o;
        sclk_raw_o <= !phase_o && (!gate_i || valid_i);
      end
    end
  end

  assign sclk_o = sclk_raw_o ^ inv_q;

  // R7: ungated shift clock alternates every cycle while running
  p_free_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !gate_i) ##1 (run_i && !gate_i) |-> (sclk_raw_o != $past(sclk_raw_o)));

  // R9: second half of each pixel is always idle
  p_low_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !sclk_raw_o);

endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
  import lcd_tim_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic        upd_i,
  input  lcd_strobe_t st_i,
  input  logic        line_start_i,
  input  logic        lfr_sel_i,
  input  logic        blank_i,
  input  logic        hs_inv_i,
  input  logic        vs_inv_i,
  input  logic        ld_inv_i,
  input  logic [DW-1:0] pix_i,
  output logic        hs_o,
  output logic        vs_o,
  output logic        ld_o,
  output logic        lfr_o,
  output logic        de_o,
  output logic [DW-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      ld_o   <= 1'b0;
      lfr_o  <= 1'b0;
      de_o   <= 1'b0;
      data_o <= '0;
    end else if (!run_i) begin
      hs_o   <= hs_inv_i;
      vs_o   <= vs_inv_i;
      ld_o   <= ld_inv_i;
      lfr_o  <= 1'b0;
      de_o   <= 1'b0;
      data_o <= '0;
    end else if (upd_i) begin
      hs_o   <= st_i.hs ^ hs_inv_i;
      vs_o   <= st_i.vs ^ vs_inv_i;
      ld_o   <= st_i.ld ^ ld_inv_i;
      de_o   <= st_i.de;
      data_o <= (st_i.de && !blank_i) ? pix_i : '0;
      if (lfr_sel_i || line_start_i) begin
        lfr_o <= !lfr_o;
      end
    end
  end

  // R1: stopped outputs rest at the inactive level of their polarity
  p_stop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (data_o == '0 && !lfr_o && hs_o == $past(hs_inv_i)
                && vs_o == $past(vs_inv_i) && ld_o == $past(ld_inv_i)));

  // R5: pixels outside the valid window carry zero data
  p_data_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !st_i.de) |=> (data_o == '0));

  // R6: blanking zeroes the bus
  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && blank_i) |=> (data_o == '0));

  // R12: per-line toggle holds between line starts
  p_lfr_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !lfr_sel_i && !line_start_i) |=> $stable(lfr_o));

  // R13: nothing moves on the edge that closes a pixel
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !upd_i) |=> ($stable(hs_o) && $stable(vs_o) && $stable(ld_o)
                           && $stable(lfr_o) && $stable(data_o)));

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_tim_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned H_SYNC   = 16,
  parameter int unsigned H_BACK   = 40,
  parameter int unsigned H_ACT    = 480,
  parameter int unsigned H_FRONT  = 16,
  parameter int unsigned V_BACK   = 8,
  parameter int unsigned V_ACT    = 272,
  parameter int unsigned V_FRONT  = 4,
  parameter int unsigned LD_WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              sclk_gate_i,
  input  logic              stn_i,
  input  logic              sclk_inv_i,
  input  logic              hs_inv_i,
  input  logic              vs_inv_i,
  input  logic              ld_inv_i,
  input  logic [1:0]        vs_width_i,
  input  logic              blank_i,
  input  logic              ld_mode_i,
  input  logic              lfr_sel_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              sclk_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              ld_o,
  output logic              lfr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned H_TOT     = H_SYNC + H_BACK + H_ACT + H_FRONT;
  localparam int unsigned H_ACT_AT  = H_SYNC + H_BACK;
  localparam int unsigned V_FIXED   = V_BACK + V_ACT + V_FRONT;
  localparam int unsigned V_TOT_MAX = 3 + V_FIXED;
  localparam int unsigned H_W       = $clog2(H_TOT);
  localparam int unsigned V_W       = $clog2(V_TOT_MAX);

  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  logic [V_W-1:0] v_last;
  logic           h_wrap;
  logic           v_wrap;
  logic           upd;
  logic           tick;
  logic           phase;
  logic           sclk_raw;
  logic           gate_eff;
  logic           de_q;
  logic           line_start;
  int unsigned    vs_len;
  lcd_strobe_t    st;

  assign gate_eff   = sclk_gate_i || stn_i;
  assign vs_len     = vs_lines(vs_width_i);
  assign v_last     = V_W'(vs_len + V_FIXED - 1);
  assign line_start = (h_cnt == '0);

  lcd_axis_ctr #(.W(H_W)) u_hctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!run_i),
    .adv_i  (tick),
    .last_i (H_W'(H_TOT - 1)),
    .cnt_o  (h_cnt),
    .wrap_o (h_wrap)
  );

  lcd_axis_ctr #(.W(V_W)) u_vctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!run_i),
    .adv_i  (h_wrap),
    .last_i (v_last),
    .cnt_o  (v_cnt),
    .wrap_o (v_wrap)
  );

  // Strobe levels for the position the counters hold now.
  always_comb begin
    st.hs = in_span(32'(h_cnt), 0, H_SYNC);
    st.vs = in_span(32'(v_cnt), 0, vs_len);
    st.de = in_span(32'(h_cnt), H_ACT_AT, H_ACT)
         && in_span(32'(v_cnt), vs_len + V_BACK, V_ACT);
    st.ld = ld_mode_i ? st.de : in_span(32'(h_cnt), 0, LD_WIDTH);
  end

  lcd_sclk_gen u_sclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .gate_i     (gate_eff),
    .valid_i    (st.de),
    .sclk_inv_i (sclk_inv_i),
    .upd_o      (upd),
    .tick_o     (tick),
    .phase_o    (phase),
    .sclk_raw_o (sclk_raw),
    .sclk_o     (sclk_o)
  );

  lcd_out_stage #(.DW(DATA_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .upd_i        (upd),
    .st_i         (st),
    .line_start_i (line_start),
    .lfr_sel_i    (lfr_sel_i),
    .blank_i      (blank_i),
    .hs_inv_i     (hs_inv_i),
    .vs_inv_i     (vs_inv_i),
    .ld_inv_i     (ld_inv_i),
    .pix_i        (pix_i),
    .hs_o         (hs_o),
    .vs_o         (vs_o),
    .ld_o         (ld_o),
    .lfr_o        (lfr_o),
    .de_o         (de_q),
    .data_o       (data_o)
  );

  // R8: a gated shift clock never pulses in a pixel without valid data
  p_gate_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && gate_eff) |=> (!sclk_raw || de_q));

  // R2: counters advance only at the close of a pixel
  p_pixel_pace_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !phase) |=> $stable(h_cnt));

  // R4: the frame counter leaves its last line only by returning to zero
  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && v_wrap) |=> (v_cnt == '0));

endmodule

// File: tb/lcd_raster_timer_tb_top.sv
module lcd_raster_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HS = 2, HB = 2, HA = 4, HF = 2, HT = 10;
  localparam int VB = 1, VA = 3, VF = 1, LDW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, sgate = 1'b0, stn = 1'b0, sinv = 1'b0;
  logic        hinv = 1'b0, vinv = 1'b0, linv = 1'b0;
  logic [1:0]  vsw = 2'b00;
  logic        blank = 1'b0, ldm = 1'b0, lsel = 1'b0;
  logic [23:0] pix = '0;
  logic        sclk, hs, vs, ld, lfr;
  logic [23:0] data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_timer #(
    .DATA_W(24), .H_SYNC(HS), .H_BACK(HB), .H_ACT(HA), .H_FRONT(HF),
    .V_BACK(VB), .V_ACT(VA), .V_FRONT(VF), .LD_WIDTH(LDW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .sclk_gate_i(sgate), .stn_i(stn),
    .sclk_inv_i(sinv), .hs_inv_i(hinv), .vs_inv_i(vinv), .ld_inv_i(linv),
    .vs_width_i(vsw), .blank_i(blank), .ld_mode_i(ldm), .lfr_sel_i(lsel),
    .pix_i(pix), .sclk_o(sclk), .hs_o(hs), .vs_o(vs), .ld_o(ld),
    .lfr_o(lfr), .data_o(data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sync_lines(input logic [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b10) return 3;
    return 1;
  endfunction

  // Stops the block and checks the resting levels (R1).
  task automatic stop_check(input string tag);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    chk("R1", {tag, " data"}, data, 0);
    chk("R1", {tag, " hsync"}, hs, hinv);
    chk("R1", {tag, " vsync"}, vs, vinv);
    chk("R1", {tag, " load"}, ld, linv);
    chk("R1", {tag, " lfr"}, lfr, 0);
    chk("R1", {tag, " sclk"}, sclk, sinv);
  endtask

  // Starts the block and compares npix pixels against the model.
  task automatic run_pixels(input int npix, input logic [23:0] base, input string tag);
    int vt;
    vt = sync_lines(vsw) + VB + VA + VF;
    @(negedge clk);
    pix = base;
    run = 1'b1;
    for (int n = 0; n < npix; n++) begin
      int h, ln, v;
      logic e_hs, e_vs, e_de, e_ld, e_lfr, e_sclk;
      logic [23:0] e_dat;
      h  = n % HT;
      ln = n / HT;
      v  = ln % vt;
      e_hs  = (h < HS);
      e_vs  = (v < sync_lines(vsw));
      e_de  = (h >= HS + HB) && (h < HS + HB + HA)
           && (v >= sync_lines(vsw) + VB) && (v < sync_lines(vsw) + VB + VA);
      e_ld  = ldm ? e_de : (h < LDW);
      e_lfr = lsel ? ((n + 1) % 2 == 1) : ((ln + 1) % 2 == 1);
      e_dat = (e_de && !blank) ? base + 24'(n) : 24'h0;
      e_sclk = ((sgate || stn) ? e_de : 1'b1) ^ sinv;
      @(posedge clk);
      @(negedge clk);
      if (n == 0) begin
        chk("R2", {tag, " first pixel hsync"}, hs, 1'b1 ^ hinv);
        chk("R2", {tag, " first pixel vsync"}, vs, 1'b1 ^ vinv);
      end
      chk("R3 R10", {tag, " hsync"}, hs, e_hs ^ hinv);
      chk("R4 R10", {tag, " vsync"}, vs, e_vs ^ vinv);
      chk("R11 R10", {tag, " load"}, ld, e_ld ^ linv);
      chk("R12", {tag, " lfr"}, lfr, e_lfr);
      chk(blank ? "R6" : "R5", {tag, " data"}, data, e_dat);
      chk("R7 R8 R9", {tag, " sclk first half"}, sclk, e_sclk);
      @(negedge clk);
      chk("R9", {tag, " sclk second half"}, sclk, sinv);
      chk("R13", {tag, " hold hsync"}, hs, e_hs ^ hinv);
      chk("R13", {tag, " hold data"}, data, e_dat);
      chk("R13", {tag, " hold lfr"}, lfr, e_lfr);
      pix = base + 24'(n + 1);
    end
  endtask

  task automatic set_defaults();
    sgate = 0; stn = 0; sinv = 0; hinv = 0; vinv = 0; linv = 0;
    vsw = 2'b00; blank = 0; ldm = 0; lsel = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "reset data", data, 0);
    chk("R1", "reset hsync", hs, 0);
    chk("R1", "reset sclk", sclk, 0);
    hinv = 1; vinv = 1; linv = 1; sinv = 1;
    stop_check("stopped inverted R10");
    set_defaults();
    stop_check("stopped plain");
  endtask

  task automatic t_basic();
    set_defaults();
    run_pixels(70, 24'hA00000, "basic");
    stop_check("basic");
  endtask

  task automatic t_vs_codes();
    for (int c = 1; c < 4; c++) begin
      set_defaults();
      vsw = 2'(c);
      run_pixels(90, 24'hB00000 + 24'(c << 12), "R4 width code");
      stop_check("R4 width code");
    end
  endtask

  task automatic t_polarity();
    set_defaults();
    hinv = 1; vinv = 1; linv = 1; sinv = 1;
    run_pixels(60, 24'hC00000, "R10 inverted");
    stop_check("R10 inverted");
    set_defaults();
    vinv = 1;
    run_pixels(20, 24'hC10000, "R10 vsync only");
    stop_check("R10 vsync only");
  endtask

  task automatic t_gating();
    set_defaults();
    sgate = 1;
    run_pixels(60, 24'hD00000, "R8 gate");
    stop_check("R8 gate");
    set_defaults();
    stn = 1;
    run_pixels(60, 24'hD10000, "R8 stn");
    stop_check("R8 stn");
  endtask

  task automatic t_blank();
    set_defaults();
    blank = 1;
    run_pixels(60, 24'hE00000, "R6 blank");
    stop_check("R6 blank");
  endtask

  task automatic t_ld_lfr();
    set_defaults();
    ldm = 1; lsel = 1;
    run_pixels(60, 24'hF00000, "R11 R12 modes");
    stop_check("R11 R12 modes");
  endtask

  task automatic t_restart();
    set_defaults();
    run_pixels(13, 24'h110000, "R2 pre-stop");
    stop_check("R2 mid-line stop");
    run_pixels(25, 24'h120000, "R2 restart");
    stop_check("R2 restart");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_vs_codes();
    t_polarity();
    t_gating();
    t_blank();
    t_ld_lfr();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule